// File: doc/BRIEF.md
# Addend Alignment Shifter

This block lines up the addend significand of a fused multiply-add against the product before the two are summed. It receives a 53-bit significand, a 13-bit two's-complement shift amount and a special-operand select. The shift is split into three cascaded stages, each with its own one-hot select: a fine stage that moves by 0 to 3, a medium stage that moves by 0, 4, 8 or 12, and a coarse stage that moves by a signed multiple of 16. The result is a 163-bit aligned window and a sticky bit that collects every bit pushed past the low end of that window.

The work is split over two registered stages. The first stage turns the shift amount into the one-hot selects and out-of-range flags and registers them with the significand. The second stage applies the three shifts and registers the window and sticky. A new operation can enter every cycle, and each result appears two clock edges after its inputs are presented. Left shifts of up to 64 are possible through the negative coarse codes. Bits moved above the top of the window are dropped.

Top module: `addend_align`

## Requirements
- R1: Results are registered and appear on the second rising clock edge after the inputs are presented. With shift amount zero, the significand occupies window bits [162:110], the rest are zero, and sticky is clear.
- R2: Shift-amount bits [1:0] move the significand right by 0, 1, 2 or 3 positions.
- R3: Shift-amount bits [3:2] move the significand right by 0, 4, 8 or 12 positions.
- R4: With the sign bit [12] clear, shift-amount bits [7:4] with a value c from 0 to 10 move the significand right by 16*c. The total right shift is the sum of the fine, medium and coarse shifts.
- R5: With the sign bit [12] set and bits [11:6] all ones (amounts -64 to -1), codes 1100, 1101, 1110 and 1111 in bits [7:4] move left by 64, 48, 32 and 16. Bits moved above window bit 162 are discarded.
- R6: For right shifts that keep part of the significand inside the window, sticky is the OR of every significand bit that lands below window bit 0.
- R7: A non-negative shift amount above 162 (including every amount whose coarse code is 1011, and every amount of 192 or more) gives an all-zero window, with sticky equal to the OR of all significand bits.
- R8: A negative shift amount below -64 saturates to a left shift of exactly 64.
- R9: When the special select is high, the window is all zeros and sticky is clear, whatever the shift amount, including amounts covered by R7 and R8.
- R10: While rst_ni is low and after its release, before any operation is clocked through, the window and sticky read zero.
- R11: Operations presented on consecutive cycles each produce their own result, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addend_i | input | 53 | Addend significand |
| shamt_i | input | 13 | Signed shift amount, two's complement, bit 12 is the sign |
| special_i | input | 1 | Special-operand select, forces a zero window |
| aligned_o | output | 163 | Aligned significand window |
| sticky_o | output | 1 | OR of the bits shifted below the window |

## Verification
An out-of-window shift and the special select can be active in the same cycle, and the two disagree on sticky. Out-of-window shifts ask for sticky to be the OR of the significand, while the special select asks for it to be clear. The bench drives both together, with a nonzero significand, an amount beyond 162 and also one below -64, and expects a zero window with sticky clear. A second case overlaps sticky collection with a partly visible significand at the edge shift of 162. Here the top bit must sit at window bit 0 and the other 52 bits must feed sticky.

// File: rtl/addend_align_pkg.sv
package addend_align_pkg;
  localparam int SIG_W       = 53;   // significand width
  localparam int WIN_W       = 163;  // aligned window width
  localparam int SHAMT_W     = 13;   // signed shift amount width
  localparam int FINE_N      = 4;
  localparam int FINE_STEP   = 1;
  localparam int MED_N       = 4;
  localparam int MED_STEP    = 4;
  localparam int COARSE_N    = 16;
  localparam int COARSE_STEP = 16;
  localparam int NEG_BASE    = 12;   // first coarse code meaning a left shift
  localparam int POS_LAST    = 10;   // last coarse code honoured as a right shift
  localparam int LEFT_MAX    = 64;   // largest left shift

  localparam int FINE_W   = SIG_W + FINE_STEP * (FINE_N - 1);
  localparam int MED_W    = FINE_W + MED_STEP * (MED_N - 1);
  localparam int RIGHT_MAX_COARSE = COARSE_STEP * POS_LAST;
  localparam int BELOW_W  = RIGHT_MAX_COARSE + MED_W - WIN_W;  // positions under the window
  localparam int OUT_W    = WIN_W + BELOW_W;
  localparam int MAX_RIGHT = WIN_W - 1;

  typedef logic [SIG_W-1:0]    sig_t;
  typedef logic [WIN_W-1:0]    win_t;
  typedef logic [SHAMT_W-1:0]  shamt_t;
  typedef logic [FINE_N-1:0]   fine_sel_t;
  typedef logic [MED_N-1:0]    med_sel_t;
  typedef logic [COARSE_N-1:0] coarse_sel_t;

  // signed shift carried by a coarse code
  function automatic int coarse_shift(input int code);
    return (code >= NEG_BASE) ? COARSE_STEP * code - COARSE_STEP * COARSE_N
                              : COARSE_STEP * code;
  endfunction
endpackage

// File: rtl/align_decode.sv
module align_decode
  import addend_align_pkg::*;
(
  input  shamt_t      shamt_i,
  input  logic        special_i,
  output fine_sel_t   fine_sel_o,
  output med_sel_t    med_sel_o,
  output coarse_sel_t coarse_sel_o,
  output logic        unf_o
);
  logic       sign;
  logic       ovf;
  logic       unf_raw;
  logic [1:0] fine_code;
  logic [1:0] med_code;
  logic [3:0] coarse_code;

  assign sign    = shamt_i[SHAMT_W-1];
  assign unf_raw = ~sign & (shamt_i[SHAMT_W-2:0] > (SHAMT_W-1)'(MAX_RIGHT));
  // below -64: upper magnitude bits not all ones
  assign ovf     = sign & ~(&shamt_i[SHAMT_W-2:6]);

  assign fine_code   = ovf ? 2'd0 : shamt_i[1:0];
  assign med_code    = ovf ? 2'd0 : shamt_i[3:2];
  assign coarse_code = ovf ? 4'(NEG_BASE) : shamt_i[7:4];

  assign fine_sel_o = fine_sel_t'(1) << fine_code;
  assign med_sel_o  = med_sel_t'(1) << med_code;
  assign unf_o      = unf_raw & ~special_i;

  for (genvar j = 0; j < COARSE_N; j++) begin : g_cdec
    if (j <= POS_LAST) begin : g_pos
      assign coarse_sel_o[j] = (coarse_code == 4'(j)) & ~sign & ~unf_raw & ~special_i;
    end else if (j >= NEG_BASE) begin : g_neg
      assign coarse_sel_o[j] = (coarse_code == 4'(j)) & sign & ~special_i;
    end else begin : g_none
      assign coarse_sel_o[j] = 1'b0;
    end
  end
endmodule

// File: rtl/align_rshift.sv
module align_rshift #(
  parameter int IN_W = 53,
  parameter int STEP = 1,
  parameter int N    = 4,
  localparam int PAD   = STEP * (N - 1),
  localparam int OUT_W = IN_W + PAD
) (
  input  logic [IN_W-1:0]  data_i,
  input  logic [N-1:0]     sel_i,
  output logic [OUT_W-1:0] data_o
);
  logic [OUT_W-1:0] term [N];

  for (genvar j = 0; j < N; j++) begin : g_term
    assign term[j] = sel_i[j] ? ({data_i, {PAD{1'b0}}} >> (STEP * j)) : '0;
  end

  always_comb begin
    data_o = '0;
    for (int j = 0; j < N; j++) data_o = data_o | term[j];
  end
endmodule

// File: rtl/align_coarse.sv
module align_coarse
  import addend_align_pkg::*;
(
  input  logic [MED_W-1:0] data_i,
  input  coarse_sel_t      sel_i,
  output logic [OUT_W-1:0] data_o
);
  localparam int WIDE_W = OUT_W + LEFT_MAX;
  // position of data_i bit 0 at coarse shift zero
  localparam int BASE   = BELOW_W + WIN_W - MED_W;

  logic [OUT_W-1:0] term [COARSE_N];

  for (genvar j = 0; j < COARSE_N; j++) begin : g_term
    localparam int K = coarse_shift(j);
    if (K > RIGHT_MAX_COARSE) begin : g_off
      assign term[j] = '0;
    end else begin : g_on
      assign term[j] = sel_i[j]
        ? OUT_W'({{(WIDE_W-MED_W){1'b0}}, data_i} << (BASE - K)) : '0;
    end
  end

  always_comb begin
    data_o = '0;
    for (int j = 0; j < COARSE_N; j++) data_o = data_o | term[j];
  end
endmodule

// File: rtl/addend_align.sv
module addend_align
  import addend_align_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SIG_W-1:0]    addend_i,
  input  logic [SHAMT_W-1:0]  shamt_i,
  input  logic                special_i,
  output logic [WIN_W-1:0]    aligned_o,
  output logic                sticky_o
);
  fine_sel_t   fine_d, fine_q;
  med_sel_t    med_d, med_q;
  coarse_sel_t coarse_d, coarse_q;
  logic        unf_d, unf_q;
  sig_t        addend_q;

  align_decode u_dec (
    .shamt_i      (shamt_i),
    .special_i    (special_i),
    .fine_sel_o   (fine_d),
    .med_sel_o    (med_d),
    .coarse_sel_o (coarse_d),
    .unf_o        (unf_d)
  );

  // stage 1: decodes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine_q   <= fine_sel_t'(1);
      med_q    <= med_sel_t'(1);
      coarse_q <= '0;
      unf_q    <= 1'b0;
      addend_q <= '0;
    end else begin
      fine_q   <= fine_d;
      med_q    <= med_d;
      coarse_q <= coarse_d;
      unf_q    <= unf_d;
      addend_q <= addend_i;
    end
  end

  logic [FINE_W-1:0] fine_out;
  logic [MED_W-1:0]  med_out;
  logic [OUT_W-1:0]  coarse_out;

  align_rshift #(.IN_W(SIG_W), .STEP(FINE_STEP), .N(FINE_N)) u_fine (
    .data_i (addend_q),
    .sel_i  (fine_q),
    .data_o (fine_out)
  );

  align_rshift #(.IN_W(FINE_W), .STEP(MED_STEP), .N(MED_N)) u_med (
    .data_i (fine_out),
    .sel_i  (med_q),
    .data_o (med_out)
  );

  align_coarse u_coarse (
    .data_i (med_out),
    .sel_i  (coarse_q),
    .data_o (coarse_out)
  );

  logic sticky_d;
  assign sticky_d = unf_q ? (|addend_q) : (|coarse_out[BELOW_W-1:0]);

  // stage 2: shifted result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_o <= '0;
      sticky_o  <= 1'b0;
    end else begin
      aligned_o <= coarse_out[OUT_W-1:BELOW_W];
      sticky_o  <= sticky_d;
    end
  end

  p_fine_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(fine_q));
  p_med_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(med_q));
  p_coarse_onehot0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(coarse_q));
  p_unf_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |-> (coarse_q == '0));
  p_unf_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |=> (aligned_o == '0) && (sticky_o == $past(|addend_q)));
  p_no_sel_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coarse_q == '0 && !unf_q) |=> (aligned_o == '0) && !sticky_o);
endmodule

// File: tb/addend_align_test.sv
module addend_align_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [52:0]  addend = '0;
  logic [12:0]  shamt = '0;
  logic         special = 1'b0;
  logic [162:0] aligned;
  logic         sticky;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addend_align uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .addend_i  (addend),
    .shamt_i   (shamt),
    .special_i (special),
    .aligned_o (aligned),
    .sticky_o  (sticky)
  );

  // independent model from the requirements
  task automatic model(input logic [52:0] a, input int s, input bit sp,
                       output logic [162:0] ea, output logic es);
    logic [291:0] ext;
    int sh;
    if (sp) begin ea = '0; es = 1'b0; return; end
    if (s > 162) begin ea = '0; es = |a; return; end
    sh = (s < -64) ? -64 : s;
    ext = {239'b0, a} << (175 - sh);
    ea = ext[227:65];
    es = |ext[64:0];
  endtask

  task automatic check(input string req, input logic [162:0] ga, input logic gs,
                       input logic [162:0] ea, input logic es);
    checks++;
    if (ga !== ea || gs !== es) begin
      errors++;
      $display("FAIL %s: aligned=%h sticky=%b expected aligned=%h sticky=%b",
               req, ga, gs, ea, es);
    end
  endtask

  task automatic run(input string req, input logic [52:0] a, input int s, input bit sp);
    logic [162:0] ea;
    logic es;
    @(negedge clk);
    addend = a; shamt = 13'(s); special = sp;
    @(negedge clk);
    @(negedge clk);
    model(a, s, sp, ea, es);
    check(req, aligned, sticky, ea, es);
  endtask

  localparam logic [52:0] PAT = 53'h1A_5C3F_0912_E7B1;

  task automatic t_reset;
    check("R10", aligned, sticky, '0, 1'b0);
  endtask

  task automatic t_zero;
    run("R1", PAT, 0, 0);
    run("R1", {1'b1, 52'b0}, 0, 0);
  endtask

  task automatic t_fine;
    for (int i = 0; i < 4; i++) run("R2", PAT, i, 0);
  endtask

  task automatic t_medium;
    for (int i = 0; i < 4; i++) run("R3", PAT, 4 * i, 0);
    run("R3", PAT, 15, 0);
  endtask

  task automatic t_coarse;
    for (int c = 0; c <= 10; c++) run("R4", PAT, 16 * c, 0);
    run("R4", PAT, 16 * 5 + 7, 0);
  endtask

  task automatic t_negative;
    run("R5", PAT, -64, 0);
    run("R5", PAT, -48, 0);
    run("R5", PAT, -32, 0);
    run("R5", PAT, -16, 0);
    run("R5", PAT, -1, 0);
    run("R5", PAT, -37, 0);
  endtask

  task automatic t_sticky;
    run("R6", PAT, 162, 0);
    run("R6", 53'h1, 111, 0);
    run("R6", 53'h1, 110, 0);
    run("R6", {1'b1, 52'b0}, 162, 0);
  endtask

  task automatic t_beyond;
    run("R7", PAT, 163, 0);
    run("R7", PAT, 176, 0);
    run("R7", PAT, 185, 0);
    run("R7", PAT, 200, 0);
    run("R7", PAT, 4095, 0);
    run("R7", 53'h0, 300, 0);
  endtask

  task automatic t_saturate;
    run("R8", PAT, -65, 0);
    run("R8", PAT, -200, 0);
    run("R8", PAT, -4096, 0);
  endtask

  task automatic t_special;
    run("R9", PAT, 0, 1);
    run("R9", PAT, 170, 1);
    run("R9", PAT, -100, 1);
    run("R9", PAT, -20, 1);
  endtask

  task automatic t_stream;
    logic [162:0] ea [3];
    logic es [3];
    int s [3] = '{5, 150, -30};
    logic [52:0] a [3] = '{PAT, ~PAT, 53'h0F0F};
    for (int i = 0; i < 3; i++) model(a[i], s[i], 1'b0, ea[i], es[i]);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      if (i >= 2) check("R11", aligned, sticky, ea[i-2], es[i-2]);
      if (i < 3) begin addend = a[i]; shamt = 13'(s[i]); special = 1'b0; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_fine();
    t_medium();
    t_coarse();
    t_negative();
    t_sticky();
    t_beyond();
    t_saturate();
    t_special();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule